// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a lane-parallel integer arithmetic unit for a 64-bit datapath. Each operand is split into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes, and the selected operation runs on every lane independently. No carry, borrow or overflow state passes from one lane to the next.

The operations are add and subtract in three flavours (wraparound, signed clamp, unsigned clamp), equality and signed greater-than compares that produce lane masks, signed 16-bit multiply returning either half of each product, multiply with pairwise accumulation, and four full-width bitwise operations. One request is accepted on any cycle that `in_valid` is high. Its result comes out of a single register stage on the next cycle. A request whose operation and lane size do not form a supported pair produces a zero result and an error pulse.

Top module: `simd_alu`

## Requirements
- R1: When `in_valid` is sampled high at a clock edge, `out_valid` is high for exactly the following cycle, carrying that request's result. When `in_valid` is sampled low, `out_valid` is low on the next cycle and `result` keeps its previous value.
- R2: Opcodes 0 (add) and 3 (subtract) wrap modulo 2^W in each lane. The lane width W is chosen by `lane_sel`: 0 means 8-bit lanes, 1 means 16-bit lanes and 2 means 32-bit lanes. A lane's carry or borrow never reaches the lane above it.
- R3: Opcodes 1 (add) and 4 (subtract) treat lanes as signed two's-complement values. A lane result that would exceed the lane's range is clamped to its largest positive or most negative value. These opcodes are valid for 8- and 16-bit lanes only.
- R4: Opcodes 2 (add) and 5 (subtract) treat lanes as unsigned values. An add that overflows clamps the lane to all ones, and a subtract that underflows clamps it to zero. These opcodes are valid for 8- and 16-bit lanes only.
- R5: Opcode 6 sets a lane to all ones when the two operand lanes are equal and to all zeros when they differ.
- R6: Opcode 7 sets a lane to all ones when the `op_a` lane, read as signed, is greater than the `op_b` lane, and to all zeros otherwise.
- R7: Opcodes 8 and 9 multiply four signed 16-bit lanes, giving a 32-bit product per lane. Opcode 8 returns the upper 16 bits of each product and opcode 9 returns the lower 16 bits. `lane_sel` is ignored.
- R8: Opcode 10 forms the four signed 16-bit products and adds them in pairs: lanes 0 and 1 go to result bits 31:0, lanes 2 and 3 go to bits 63:32. Each sum wraps modulo 2^32. `lane_sel` is ignored.
- R9: Opcodes 11, 12, 13 and 14 compute `op_a & op_b`, `~op_a & op_b`, `op_a | op_b` and `op_a ^ op_b` across all 64 bits. `lane_sel` is ignored.
- R10: Opcode 15 is illegal with any `lane_sel`. `lane_sel` 3 is illegal with opcodes 0 to 7. `lane_sel` 2 is illegal with opcodes 1, 2, 4 and 5. An illegal request produces a zero `result`, with `illegal` high in its output cycle only.
- R11: While `rst_n` is low, `out_valid`, `illegal` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| opcode | input | 4 | Operation code, values 0 to 15 |
| lane_sel | input | 2 | Lane size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Registered result |
| illegal | output | 1 | Unsupported opcode/lane-size pair, one-cycle pulse |

## Verification
The checker assumes that whenever `in_valid` is high, `opcode`, `lane_sel` and both operands carry known values. It also assumes these inputs change only away from the rising edge. The stimulus meets both assumptions by driving every input to a defined value on the falling edge and holding it for a whole cycle. The mask and bitwise properties compare each result with the inputs captured one cycle earlier. The stimulus therefore mixes idle gaps, back-to-back requests and all four `lane_sel` codes, including the reserved one, so that every property is exercised on both its triggering and its non-triggering side.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD_WR  = 4'd0,
      OP_ADD_SS  = 4'd1,
      OP_ADD_US  = 4'd2,
      OP_SUB_WR  = 4'd3,
      OP_SUB_SS  = 4'd4,
      OP_SUB_US  = 4'd5,
      OP_CMP_EQ  = 4'd6,
      OP_CMP_GT  = 4'd7,
      OP_MUL_HI  = 4'd8,
      OP_MUL_LO  = 4'd9,
      OP_MUL_ACC = 4'd10,
      OP_AND     = 4'd11,
      OP_ANDN    = 4'd12,
      OP_OR      = 4'd13,
      OP_XOR     = 4'd14,
      OP_RSVD    = 4'd15
   } simd_op_e;

   typedef enum logic [1:0] {
      LANE_8    = 2'd0,
      LANE_16   = 2'd1,
      LANE_32   = 2'd2,
      LANE_RSVD = 2'd3
   } lane_sz_e;

   localparam int NUM_SIZES = 3;

   // Legality of an opcode / lane-size pair.
   function automatic logic pair_legal(simd_op_e op, lane_sz_e sz);
      logic ok;
      case (op)
         OP_ADD_WR, OP_SUB_WR,
         OP_CMP_EQ, OP_CMP_GT:   ok = (sz != LANE_RSVD);
         OP_ADD_SS, OP_ADD_US,
         OP_SUB_SS, OP_SUB_US:   ok = (sz == LANE_8) || (sz == LANE_16);
         OP_RSVD:                ok = 1'b0;
         default:                ok = 1'b1;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/simd_lane_arith.sv
module simd_lane_arith
   import simd_alu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8,
   parameter bit SAT_OK = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  simd_op_e          op,
   output logic [DATA_W-1:0] res
);
   localparam int NUM_LANES = DATA_W / LANE_W;
   localparam logic [LANE_W-1:0] ONES  = '1;
   localparam logic [LANE_W-1:0] S_MAX = {1'b0, {(LANE_W-1){1'b1}}};
   localparam logic [LANE_W-1:0] S_MIN = {1'b1, {(LANE_W-1){1'b0}}};

   if (DATA_W % LANE_W != 0) begin : g_bad_width
      $error("simd_lane_arith: DATA_W must be a multiple of LANE_W");
   end

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic [LANE_W-1:0] x, y, sum_w, dif_w;
      logic [LANE_W-1:0] add_ss, sub_ss, add_us, sub_us;
      logic              eq_hit, gt_hit;

      assign x      = a[l*LANE_W +: LANE_W];
      assign y      = b[l*LANE_W +: LANE_W];
      assign sum_w  = x + y;
      assign dif_w  = x - y;
      assign eq_hit = (x == y);
      assign gt_hit = ($signed(x) > $signed(y));

      if (SAT_OK) begin : g_sat
         logic [LANE_W:0] sum_c, dif_c;
         logic            s_ovf, d_ovf;
         assign sum_c  = {1'b0, x} + {1'b0, y};
         assign dif_c  = {1'b0, x} - {1'b0, y};
         assign s_ovf  = (x[LANE_W-1] == y[LANE_W-1]) && (sum_w[LANE_W-1] != x[LANE_W-1]);
         assign d_ovf  = (x[LANE_W-1] != y[LANE_W-1]) && (dif_w[LANE_W-1] != x[LANE_W-1]);
         assign add_ss = s_ovf ? (x[LANE_W-1] ? S_MIN : S_MAX) : sum_w;
         assign sub_ss = d_ovf ? (x[LANE_W-1] ? S_MIN : S_MAX) : dif_w;
         assign add_us = sum_c[LANE_W] ? ONES : sum_c[LANE_W-1:0];
         assign sub_us = dif_c[LANE_W] ? '0   : dif_c[LANE_W-1:0];
      end else begin : g_nosat
         assign add_ss = '0;
         assign sub_ss = '0;
         assign add_us = '0;
         assign sub_us = '0;
      end

      always_comb begin
         case (op)
            OP_ADD_WR: res[l*LANE_W +: LANE_W] = sum_w;
            OP_SUB_WR: res[l*LANE_W +: LANE_W] = dif_w;
            OP_ADD_SS: res[l*LANE_W +: LANE_W] = add_ss;
            OP_SUB_SS: res[l*LANE_W +: LANE_W] = sub_ss;
            OP_ADD_US: res[l*LANE_W +: LANE_W] = add_us;
            OP_SUB_US: res[l*LANE_W +: LANE_W] = sub_us;
            OP_CMP_EQ: res[l*LANE_W +: LANE_W] = eq_hit ? ONES : '0;
            OP_CMP_GT: res[l*LANE_W +: LANE_W] = gt_hit ? ONES : '0;
            default:   res[l*LANE_W +: LANE_W] = '0;
         endcase
      end
   end

endmodule

// File: rtl/simd_mul16.sv
module simd_mul16 #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] mul_hi,
   output logic [DATA_W-1:0] mul_lo,
   output logic [DATA_W-1:0] mul_acc
);
   localparam int HW       = 16;
   localparam int PW       = 2 * HW;
   localparam int NUM_MUL  = DATA_W / HW;
   localparam int NUM_PAIR = NUM_MUL / 2;

   if (DATA_W % PW != 0) begin : g_bad_width
      $error("simd_mul16: DATA_W must be a multiple of 32");
   end

   logic [PW-1:0] prod [NUM_MUL];

   for (genvar m = 0; m < NUM_MUL; m++) begin : g_mul
      assign prod[m] = PW'($signed(a[m*HW +: HW]) * $signed(b[m*HW +: HW]));
      assign mul_hi[m*HW +: HW] = prod[m][PW-1:HW];
      assign mul_lo[m*HW +: HW] = prod[m][HW-1:0];
   end

   for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
      assign mul_acc[p*PW +: PW] = prod[2*p] + prod[2*p+1];
   end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
   import simd_alu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [3:0]        opcode,
   input  logic [1:0]        lane_sel,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              illegal
);
   if (DATA_W % 32 != 0 || DATA_W < 32) begin : g_bad_width
      $error("simd_alu: DATA_W must be a positive multiple of 32");
   end

   simd_op_e          op;
   lane_sz_e          sz;
   logic              legal;
   logic [DATA_W-1:0] lane_res [NUM_SIZES];
   logic [DATA_W-1:0] mul_hi, mul_lo, mul_acc;
   logic [DATA_W-1:0] nxt;

   assign op    = simd_op_e'(opcode);
   assign sz    = lane_sz_e'(lane_sel);
   assign legal = pair_legal(op, sz);

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      simd_lane_arith #(
         .DATA_W (DATA_W),
         .LANE_W (8 << s),
         .SAT_OK (s < 2)
      ) u_arith (
         .a   (op_a),
         .b   (op_b),
         .op  (op),
         .res (lane_res[s])
      );
   end

   simd_mul16 #(.DATA_W(DATA_W)) u_mul (
      .a       (op_a),
      .b       (op_b),
      .mul_hi  (mul_hi),
      .mul_lo  (mul_lo),
      .mul_acc (mul_acc)
   );

   always_comb begin
      nxt = '0;
      if (legal) begin
         case (op)
            OP_MUL_HI:  nxt = mul_hi;
            OP_MUL_LO:  nxt = mul_lo;
            OP_MUL_ACC: nxt = mul_acc;
            OP_AND:     nxt = op_a & op_b;
            OP_ANDN:    nxt = ~op_a & op_b;
            OP_OR:      nxt = op_a | op_b;
            OP_XOR:     nxt = op_a ^ op_b;
            default: begin
               case (sz)
                  LANE_8:  nxt = lane_res[0];
                  LANE_16: nxt = lane_res[1];
                  LANE_32: nxt = lane_res[2];
                  default: nxt = '0;
               endcase
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         illegal   <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         illegal   <= in_valid && !legal;
         if (in_valid) result <= nxt;
      end
   end

endmodule

// File: rtl/simd_alu_checker.sv
module simd_alu_checker
   import simd_alu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] op_a,
   input logic [DATA_W-1:0] op_b,
   input logic [3:0]        opcode,
   input logic [1:0]        lane_sel,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic              illegal
);
   function automatic logic lanes_are_masks(logic [DATA_W-1:0] v, logic [1:0] sel);
      int w;
      logic ok;
      w  = 8 << sel;
      ok = 1'b1;
      for (int i = 0; i < DATA_W; i++)
         if (v[i] != v[(i / w) * w]) ok = 1'b0;
      return ok;
   endfunction

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result)));

   assert_zero_on_illegal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (out_valid && result == '0));

   assert_reserved_flagged_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == OP_RSVD) |=> illegal);

   // Covers R5 and R6: compare results are whole-lane masks.
   assert_cmp_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (opcode == OP_CMP_EQ || opcode == OP_CMP_GT) && lane_sel != LANE_RSVD)
      |=> lanes_are_masks(result, $past(lane_sel)));

   assert_xor_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == OP_XOR) |=> (result == $past(op_a ^ op_b)));

endmodule

bind simd_alu simd_alu_checker #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_a      (op_a),
   .op_b      (op_b),
   .opcode    (opcode),
   .lane_sel  (lane_sel),
   .out_valid (out_valid),
   .result    (result),
   .illegal   (illegal)
);

// File: tb/simd_alu_bench.sv
module simd_alu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] op_a = '0, op_b = '0;
   logic [3:0]  opcode = '0;
   logic [1:0]  lane_sel = '0;
   logic        out_valid, illegal;
   logic [63:0] result;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [63:0] res;
      logic        ill;
      string       tag;
   } exp_t;
   exp_t sb [$];
   logic [63:0] last_res = '0;

   always #5 clk = ~clk;

   simd_alu u_simd_alu (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .opcode(opcode), .lane_sel(lane_sel), .out_valid(out_valid),
      .result(result), .illegal(illegal)
   );

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Reference model written from the requirements: {illegal, result}.
   function automatic logic [64:0] model(logic [63:0] a, logic [63:0] b,
                                         logic [3:0] op, logic [1:0] sz);
      logic [63:0] r = '0;
      bit ok;
      int w;
      longint m, half, p [4];
      ok = 1'b1;
      if (op == 15) ok = 1'b0;
      if (op <= 7 && sz == 3) ok = 1'b0;
      if ((op == 1 || op == 2 || op == 4 || op == 5) && sz == 2) ok = 1'b0;
      if (!ok) return {1'b1, 64'h0};
      w = 8 << sz;
      m = (64'sd1 <<< w) - 1;
      half = 64'sd1 <<< (w - 1);
      for (int k = 0; k < 4; k++)
         p[k] = longint'($signed(a[k*16 +: 16])) * longint'($signed(b[k*16 +: 16]));
      case (op)
         8:  for (int k = 0; k < 4; k++) r[k*16 +: 16] = 16'(p[k] >>> 16);
         9:  for (int k = 0; k < 4; k++) r[k*16 +: 16] = 16'(p[k]);
         10: for (int k = 0; k < 2; k++) r[k*32 +: 32] = 32'(p[2*k] + p[2*k+1]);
         11: r = a & b;
         12: r = ~a & b;
         13: r = a | b;
         14: r = a ^ b;
         default:
            for (int l = 0; l < 64 / w; l++) begin
               longint ua, ub, sa, sb, v;
               ua = longint'((a >> (l * w))) & m;
               ub = longint'((b >> (l * w))) & m;
               sa = (ua >= half) ? ua - (m + 1) : ua;
               sb = (ub >= half) ? ub - (m + 1) : ub;
               case (op)
                  0: v = ua + ub;
                  3: v = ua - ub;
                  1: begin v = sa + sb; if (v > half - 1) v = half - 1; if (v < -half) v = -half; end
                  4: begin v = sa - sb; if (v > half - 1) v = half - 1; if (v < -half) v = -half; end
                  2: begin v = ua + ub; if (v > m) v = m; end
                  5: begin v = ua - ub; if (v < 0) v = 0; end
                  6: v = (ua == ub) ? m : 0;
                  default: v = (sa > sb) ? m : 0;
               endcase
               r = r | (64'(v & m) << (l * w));
            end
      endcase
      return {1'b0, r};
   endfunction

   task automatic drive(logic [63:0] a, logic [63:0] b, logic [3:0] op,
                        logic [1:0] sz, string tag);
      logic [64:0] e;
      exp_t it;
      @(negedge clk);
      in_valid = 1'b1; op_a = a; op_b = b; opcode = op; lane_sel = sz;
      e = model(a, b, op, sz);
      it.res = e[63:0]; it.ill = e[64]; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0; op_a = 64'hDEAD_BEEF_0BAD_F00D; op_b = ~op_a; opcode = 4'd11;
      end
   endtask

   // Monitor: pops the scoreboard when a result appears.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && !done) begin
            if (out_valid) begin
               if (sb.size() == 0) begin
                  check(1'b0, "R1 unexpected out_valid", result, 64'h0);
               end else begin
                  exp_t it;
                  it = sb.pop_front();
                  check(result == it.res, it.tag, result, it.res);
                  check(illegal == it.ill, {it.tag, " illegal flag (R10)"},
                        64'(illegal), 64'(it.ill));
                  last_res = result;
               end
            end else begin
               check(result == last_res && !illegal, "R1 idle hold", result, last_res);
               check(sb.size() == 0, "R1 missing out_valid", 64'(sb.size()), 64'h0);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && illegal == 1'b0 && result == '0, "R11 reset state",
            result, 64'h0);
      rst_n = 1'b1;
      idle(2);
      // R2 wraparound, lanes isolated
      drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 4'd0, 2'd0, "R2 add8 wrap");
      drive(64'hFFFF_0001_8000_7FFF, 64'h0001_FFFF_8000_0001, 4'd0, 2'd1, "R2 add16 wrap");
      drive(64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 4'd0, 2'd2, "R2 add32 wrap");
      drive(64'h0000_0000_0000_0000, 64'h0100_0001_0001_0001, 4'd3, 2'd0, "R2 sub8 wrap");
      drive(64'h0000_0001_0000_0000, 64'h0000_0002_0000_0001, 4'd3, 2'd2, "R2 sub32 wrap");
      // R3 signed saturation
      drive(64'h7F80_7F80_0102_FF00, 64'h0180_01FF_0203_FF80, 4'd1, 2'd0, "R3 add8 ssat");
      drive(64'h8000_7FFF_1234_FFFF, 64'h0001_FFFF_0001_8000, 4'd4, 2'd0, "R3 sub8 ssat");
      drive(64'h7FFF_8000_7FFF_0005, 64'h0001_FFFF_8001_FFF0, 4'd1, 2'd1, "R3 add16 ssat");
      drive(64'h8000_7FFF_0000_1000, 64'h0001_FFFF_8000_2000, 4'd4, 2'd1, "R3 sub16 ssat");
      // R4 unsigned saturation
      drive(64'hFF80_0102_FE00_7F7F, 64'h0180_FF02_0300_8080, 4'd2, 2'd0, "R4 add8 usat");
      drive(64'h0010_0280_00FF_0000, 64'h0110_0380_FF00_0001, 4'd5, 2'd0, "R4 sub8 usat");
      drive(64'hFFFF_8000_0001_1234, 64'h0001_8000_FFFF_0000, 4'd2, 2'd1, "R4 add16 usat");
      drive(64'h0000_8000_0005_FFFF, 64'h0001_7FFF_0006_FFFF, 4'd5, 2'd1, "R4 sub16 usat");
      // R5 / R6 compares
      drive(64'h1122_3344_5566_7788, 64'h1122_3345_5566_0088, 4'd6, 2'd0, "R5 eq8");
      drive(64'h1122_3344_5566_7788, 64'h1122_3344_5567_7788, 4'd6, 2'd2, "R5 eq32");
      drive(64'h80FF_7F01_0005_FFFF, 64'h7F00_8002_0004_FFFE, 4'd7, 2'd0, "R6 gt8 signed");
      drive(64'h8000_0001_7FFF_FFFF, 64'h7FFF_0000_8000_FFFF, 4'd7, 2'd1, "R6 gt16 signed");
      drive(64'hFFFF_FFFF_0000_0000, 64'h0000_0000_FFFF_FFFF, 4'd7, 2'd2, "R6 gt32 signed");
      // R7 multiply halves, lane_sel ignored
      drive(64'h8000_7FFF_FFFF_1234, 64'h8000_7FFF_0002_5678, 4'd8, 2'd3, "R7 mul hi");
      drive(64'h8000_7FFF_FFFF_1234, 64'h8000_7FFF_0002_5678, 4'd9, 2'd0, "R7 mul lo");
      // R8 multiply-accumulate pairs
      drive(64'h8000_8000_0003_FFFE, 64'h8000_8000_0004_0005, 4'd10, 2'd1, "R8 madd");
      drive(64'h7FFF_0001_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_0001, 4'd10, 2'd2, "R8 madd signs");
      // R9 bitwise
      drive(64'hF0F0_1234_AAAA_0000, 64'hFF00_FFFF_5555_FFFF, 4'd11, 2'd3, "R9 and");
      drive(64'hF0F0_1234_AAAA_0000, 64'hFF00_FFFF_5555_FFFF, 4'd12, 2'd0, "R9 andn");
      drive(64'hF0F0_1234_AAAA_0000, 64'hFF00_FFFF_5555_FFFF, 4'd13, 2'd1, "R9 or");
      drive(64'hF0F0_1234_AAAA_0000, 64'hFF00_FFFF_5555_FFFF, 4'd14, 2'd2, "R9 xor");
      // R10 illegal pairs, back to back, then a legal one
      drive(64'h1, 64'h2, 4'd15, 2'd0, "R10 reserved opcode");
      drive(64'h1, 64'h2, 4'd0, 2'd3, "R10 reserved size");
      drive(64'h1, 64'h2, 4'd1, 2'd2, "R10 sat32 signed");
      drive(64'h1, 64'h2, 4'd5, 2'd2, "R10 sat32 unsigned");
      drive(64'h1, 64'h2, 4'd0, 2'd2, "R10 legal after illegal");
      idle(3);
      // R1 idle gaps between requests
      for (int i = 0; i < 300; i++) begin
         logic [63:0] ra, rb;
         ra = {$urandom, $urandom};
         rb = (i % 5 == 0) ? ra : {$urandom, $urandom};
         drive(ra, rb, 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), "R1 random mix");
         if (i % 7 == 0) idle(1);
      end
      idle(4);
      check(sb.size() == 0, "R1 drain", 64'(sb.size()), 64'h0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule